// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port with 32 pins by default. It controls tristate pads: each pin has an output level and an output enable, and the pad input comes back through a synchronizer. Software never writes a direction register. A pin becomes an output as a side effect of writing its bit to the drive-high register or the drive-low register. Writing the pin's bit to the release register turns it back into an input. A read-only level register returns the synchronized pad levels. It reads as zero until software has written the arm register once after reset.

The register bus has two independent write ports, A and B, plus one read port. All three take word addresses. The offsets are: 0 drive-high, 1 drive-low, 2 release, 3 arm, 4 pin level. Offsets 5 to 7 are unused. Pin n maps to bit n of every register. Writes take effect at the clock edge that samples them. Read data is registered and appears one cycle after the read request.

Top module: `sc_gpio_port`

## Requirements
- R1: After reset, pad_oe and pad_out are all zero, and a read of offset 4 returns zero whatever the pad levels are.
- R2: A write to offset 0 drives every pin whose data bit is 1 high on pad_out. Other pins keep their level.
- R3: A write to offset 1 drives every pin whose data bit is 1 low on pad_out. Other pins keep their level.
- R4: A write to offset 0 or offset 1 sets pad_oe for every pin whose data bit is 1. The pad_oe bits of other pins keep their value.
- R5: A write to offset 2 clears pad_oe for every pin whose data bit is 1. pad_out is left unchanged.
- R6: A read of offset 4 returns zero until some write to offset 3 has occurred after reset. The data value of that write, including zero, does not matter.
- R7: Once armed, offset 4 returns the pad_in levels through a two-flop synchronizer. A pad change made just before edge k is returned by a read whose request is sampled at edge k+2. Requests sampled at edges k and k+1 return the old level.
- R8: A write of an all-zero mask to offset 0, 1 or 2 changes neither pad_out nor pad_oe.
- R9: Reads of offsets 0 to 3 and of unused offsets 5 to 7 return zero.
- R10: When one port writes offset 0 and the other writes offset 1 in the same cycle, overlapping pins go low and non-overlapping pins follow their own write. A same-cycle release of a pin overrides a drive write for that pin's pad_oe.
- R11: pad_out and pad_oe take their new values at the clock edge that samples the write.
- R12: When both ports write the same offset in the same cycle, the effect is the union of the two masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wa_valid | input | 1 | Write port A request |
| wa_addr | input | 3 | Write port A word offset |
| wa_data | input | 32 | Write port A data / pin mask |
| wb_valid | input | 1 | Write port B request |
| wb_addr | input | 3 | Write port B word offset |
| wb_data | input | 32 | Write port B data / pin mask |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read word offset |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 = driving |

## Verification
The hardest situation to reach is a same-cycle collision on the two write ports. It can be a drive-high against a drive-low, or a release against a drive. The bench brings it about with a task that drives both ports in the same cycle, with overlapping and non-overlapping masks. The arming rule is the other subtle case. The bench holds the pads at a nonzero pattern, reads zero before arming, and then arms with an all-zero data word. It also reads back to back around a pad change to pin down the two-cycle synchronizer delay.

// File: rtl/sc_gpio_pkg.sv
// Package: shared constants for the set/clear GPIO port.
// Assumes word addressing with a 3-bit offset field.
package sc_gpio_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DRIVE_HI = 3'd0,
        OFS_DRIVE_LO = 3'd1,
        OFS_RELEASE  = 3'd2,
        OFS_ARM      = 3'd3,
        OFS_LEVEL    = 3'd4
    } gpio_ofs_e;

    // Per-port decoded write actions
    typedef struct packed {
        logic arm;
        logic hi;
        logic lo;
        logic rel;
    } wr_kind_t;

endpackage

// File: rtl/sc_gpio_wr_decode.sv
// Module: decodes one write port into pin masks and an arm pulse.
// Assumes valid is qualified for one cycle per write; no backpressure.
module sc_gpio_wr_decode
    import sc_gpio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic                     valid,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [N_PINS-1:0]        data,
    output logic [N_PINS-1:0]        hi_mask,
    output logic [N_PINS-1:0]        lo_mask,
    output logic [N_PINS-1:0]        rel_mask,
    output logic                     arm
);

    wr_kind_t kind;

    // Classify the write by its offset
    always_comb begin
        kind = '0;
        if (valid) begin
            unique case (addr)
                OFS_DRIVE_HI: kind.hi  = 1'b1;
                OFS_DRIVE_LO: kind.lo  = 1'b1;
                OFS_RELEASE:  kind.rel = 1'b1;
                OFS_ARM:      kind.arm = 1'b1;
                default:      kind     = '0;
            endcase
        end
    end

    // Gate the data mask by the decoded action
    always_comb begin
        hi_mask  = kind.hi  ? data : '0;
        lo_mask  = kind.lo  ? data : '0;
        rel_mask = kind.rel ? data : '0;
        arm      = kind.arm;
    end

endmodule

// File: rtl/sc_gpio_pin_bank.sv
// Module: per-pin output latch and output enable.
// Assumes the masks are already merged across write ports.
// Priority: low beats high for the level, and release beats drive for the enable.
module sc_gpio_pin_bank #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] hi_mask,
    input  logic [N_PINS-1:0] lo_mask,
    input  logic [N_PINS-1:0] rel_mask,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic lvl_q;
        logic oe_q;

        // Output level latch: low has priority over high
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q <= 1'b0;
            else if (lo_mask[p])
                lvl_q <= 1'b0;
            else if (hi_mask[p])
                lvl_q <= 1'b1;
        end

        // Output enable: release has priority over an implicit drive
        always_ff @(posedge clk) begin
            if (!rst_n)
                oe_q <= 1'b0;
            else if (rel_mask[p])
                oe_q <= 1'b0;
            else if (hi_mask[p] || lo_mask[p])
                oe_q <= 1'b1;
        end

        assign pad_out[p] = lvl_q;
        assign pad_oe[p]  = oe_q;
    end

endmodule

// File: rtl/sc_gpio_in_sync.sv
// Module: arm latch and two-flop pad synchronizer.
// Assumes pad_in is asynchronous; the synchronizer is held at zero until armed.
module sc_gpio_in_sync #(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [N_PINS-1:0] pad_in,
    output logic              armed,
    output logic [N_PINS-1:0] level
);

    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;

    // Sticky arm latch, set by any write to the arm offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (arm)
            armed <= 1'b1;
    end

    // Two-stage synchronizer, cleared while inputs are not armed
    always_ff @(posedge clk) begin
        if (!rst_n || !armed) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    assign level = sync_q;

endmodule

// File: rtl/sc_gpio_port.sv
// Module: top of the set/clear GPIO port.
// Two write ports and one read port; registered read data.
// Assumes both write ports may collide on any offset in the same cycle.
module sc_gpio_port
    import sc_gpio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_valid,
    input  logic [2:0]        wa_addr,
    input  logic [N_PINS-1:0] wa_data,
    input  logic              wb_valid,
    input  logic [2:0]        wb_addr,
    input  logic [N_PINS-1:0] wb_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_addr,
    output logic [N_PINS-1:0] rd_data,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);

    localparam int N_WPORTS = 2;

    logic [N_WPORTS-1:0]             w_valid;
    logic [N_WPORTS-1:0][ADDR_W-1:0] w_addr;
    logic [N_WPORTS-1:0][N_PINS-1:0] w_data;
    logic [N_WPORTS-1:0][N_PINS-1:0] p_hi;
    logic [N_WPORTS-1:0][N_PINS-1:0] p_lo;
    logic [N_WPORTS-1:0][N_PINS-1:0] p_rel;
    logic [N_WPORTS-1:0]             p_arm;

    logic [N_PINS-1:0] hi_mask;
    logic [N_PINS-1:0] lo_mask;
    logic [N_PINS-1:0] rel_mask;
    logic              arm_any;
    logic              armed;
    logic [N_PINS-1:0] level;

    assign w_valid = {wb_valid, wa_valid};
    assign w_addr  = {wb_addr, wa_addr};
    assign w_data  = {wb_data, wa_data};

    for (genvar w = 0; w < N_WPORTS; w++) begin : g_wport
        sc_gpio_wr_decode #(.N_PINS(N_PINS)) u_dec (
            .valid    (w_valid[w]),
            .addr     (w_addr[w]),
            .data     (w_data[w]),
            .hi_mask  (p_hi[w]),
            .lo_mask  (p_lo[w]),
            .rel_mask (p_rel[w]),
            .arm      (p_arm[w])
        );
    end

    // Merge the per-port actions into one set of masks
    always_comb begin
        hi_mask  = '0;
        lo_mask  = '0;
        rel_mask = '0;
        arm_any  = 1'b0;
        for (int w = 0; w < N_WPORTS; w++) begin
            hi_mask  = hi_mask  | p_hi[w];
            lo_mask  = lo_mask  | p_lo[w];
            rel_mask = rel_mask | p_rel[w];
            arm_any  = arm_any  | p_arm[w];
        end
    end

    sc_gpio_pin_bank #(.N_PINS(N_PINS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_mask  (hi_mask),
        .lo_mask  (lo_mask),
        .rel_mask (rel_mask),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    sc_gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_any),
        .pad_in (pad_in),
        .armed  (armed),
        .level  (level)
    );

    // Registered read: only the level offset returns data
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= (rd_addr == OFS_LEVEL) ? level : '0;
    end

endmodule

// File: rtl/sc_gpio_port_chk.sv
// Checker: temporal properties of the set/clear GPIO port, bound to the top.
module sc_gpio_port_chk
    import sc_gpio_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_PINS-1:0] hi_mask,
    input logic [N_PINS-1:0] lo_mask,
    input logic [N_PINS-1:0] rel_mask,
    input logic              arm_any,
    input logic              armed,
    input logic              rd_en,
    input logic [2:0]        rd_addr,
    input logic [N_PINS-1:0] rd_data,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe
);

    // R2
    drive_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_mask & ~lo_mask) != '0) |=>
        ((pad_out & $past(hi_mask & ~lo_mask)) == $past(hi_mask & ~lo_mask)));

    // R3
    drive_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_mask != '0) |=> ((pad_out & $past(lo_mask)) == '0));

    // R4
    implicit_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((hi_mask | lo_mask) & ~rel_mask) != '0) |=>
        ((pad_oe & $past((hi_mask | lo_mask) & ~rel_mask)) ==
         $past((hi_mask | lo_mask) & ~rel_mask)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_mask != '0) |=> ((pad_oe & $past(rel_mask)) == '0));

    // R5
    release_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rel_mask != '0) && ((hi_mask | lo_mask) == '0)) |=> $stable(pad_out));

    // R6
    unarmed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr == OFS_LEVEL) && !armed) |=> (rd_data == '0));

    // R6
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed || arm_any) |=> armed);

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_mask | lo_mask | rel_mask) == '0) |=> ($stable(pad_out) && $stable(pad_oe)));

    // R9
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr != OFS_LEVEL)) |=> (rd_data == '0));

endmodule

bind sc_gpio_port sc_gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_mask  (hi_mask),
    .lo_mask  (lo_mask),
    .rel_mask (rel_mask),
    .arm_any  (arm_any),
    .armed    (armed),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
);

// File: tb/tb_sc_gpio_port.sv
`timescale 1ns/1ps
module tb_sc_gpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wa_valid = 1'b0;
    logic [2:0]  wa_addr = '0;
    logic [31:0] wa_data = '0;
    logic        wb_valid = 1'b0;
    logic [2:0]  wb_addr = '0;
    logic [31:0] wb_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_out = '0;
    logic [31:0] exp_oe  = '0;

    always #5 clk = ~clk;

    sc_gpio_port dut (
        .clk(clk), .rst_n(rst_n),
        .wa_valid(wa_valid), .wa_addr(wa_addr), .wa_data(wa_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected-state model from R2..R5, R10, R12
    task automatic model(input logic av, input logic [2:0] aa, input logic [31:0] ad,
                         input logic bv, input logic [2:0] ba, input logic [31:0] bd);
        logic [31:0] s, c, r;
        s = ((av && aa == 3'd0) ? ad : 32'h0) | ((bv && ba == 3'd0) ? bd : 32'h0);
        c = ((av && aa == 3'd1) ? ad : 32'h0) | ((bv && ba == 3'd1) ? bd : 32'h0);
        r = ((av && aa == 3'd2) ? ad : 32'h0) | ((bv && ba == 3'd2) ? bd : 32'h0);
        exp_out = (exp_out | s) & ~c;
        exp_oe  = (exp_oe | s | c) & ~r;
    endtask

    // Dual-port write in one cycle; called and returns at a negedge
    task automatic wr2(input logic av, input logic [2:0] aa, input logic [31:0] ad,
                       input logic bv, input logic [2:0] ba, input logic [31:0] bd);
        wa_valid = av; wa_addr = aa; wa_data = ad;
        wb_valid = bv; wb_addr = ba; wb_data = bd;
        @(posedge clk);
        @(negedge clk);
        wa_valid = 1'b0; wb_valid = 1'b0;
        model(av, aa, ad, bv, ba, bd);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr2(1'b1, a, d, 1'b0, 3'd0, 32'h0);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check_pads(input string req);
        check({req, " pad_out"}, pad_out, exp_out);
        check({req, " pad_oe"}, pad_oe, exp_oe);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        pad_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check_pads("R1");
        rd(3'd4, d);
        check("R1 level after reset", d, 32'h0);
    endtask

    task automatic t_unarmed_then_arm();
        logic [31:0] d;
        pad_in = 32'hA5A5_A5A5;
        repeat (4) @(negedge clk);
        rd(3'd4, d);
        check("R6 unarmed level", d, 32'h0);
        wr(3'd3, 32'h0);
        repeat (3) @(negedge clk);
        rd(3'd4, d);
        check("R6 armed by zero-data write", d, 32'hA5A5_A5A5);
    endtask

    task automatic t_sync_latency();
        logic [31:0] d;
        pad_in = 32'h1234_5678;
        rd(3'd4, d);
        check("R7 edge k old", d, 32'hA5A5_A5A5);
        rd(3'd4, d);
        check("R7 edge k+1 old", d, 32'hA5A5_A5A5);
        rd(3'd4, d);
        check("R7 edge k+2 new", d, 32'h1234_5678);
    endtask

    task automatic t_drive();
        wr(3'd0, 32'h0000_00FF);
        check_pads("R2 R4 R11 drive high");
        check("R11 exact", pad_out, 32'h0000_00FF);
        wr(3'd1, 32'h0000_000F);
        check_pads("R3 drive low");
        check("R3 exact", pad_out, 32'h0000_00F0);
        wr(3'd1, 32'h0000_0F00);
        check_pads("R4 low makes output");
        check("R4 exact oe", pad_oe, 32'h0000_0FFF);
    endtask

    task automatic t_release();
        wr(3'd2, 32'h0000_00F0);
        check_pads("R5 release");
        check("R5 exact oe", pad_oe, 32'h0000_0F0F);
        check("R5 level kept", pad_out, 32'h0000_00F0);
    endtask

    task automatic t_zero_mask();
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);
        check("R8 out", pad_out, 32'h0000_00F0);
        check("R8 oe", pad_oe, 32'h0000_0F0F);
    endtask

    task automatic t_wo_reads();
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            if (a != 4) begin
                rd(3'(a), d);
                check($sformatf("R9 read offset %0d", a), d, 32'h0);
            end
        end
    endtask

    task automatic t_collide();
        wr2(1'b1, 3'd0, 32'hFF00_0000, 1'b1, 3'd1, 32'h0F00_0000);
        check_pads("R10 high vs low");
        check("R10 exact out", pad_out & 32'hFF00_0000, 32'hF000_0000);
        wr2(1'b1, 3'd0, 32'h00F0_0000, 1'b1, 3'd2, 32'h0030_0000);
        check_pads("R10 drive vs release");
        check("R10 exact oe", pad_oe & 32'h00F0_0000, 32'h00C0_0000);
    endtask

    task automatic t_same_offset();
        wr2(1'b1, 3'd0, 32'h0001_0000, 1'b1, 3'd0, 32'h0002_0000);
        check_pads("R12 union");
        check("R12 exact", pad_out & 32'h0003_0000, 32'h0003_0000);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_pads("R1 in reset");
        rst_n = 1'b1;
        t_reset();
        t_unarmed_then_arm();
        t_sync_latency();
        t_drive();
        t_release();
        t_zero_mask();
        t_wo_reads();
        t_collide();
        t_same_offset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule